// File: doc/BRIEF.md
# DRAM Refresh Address and Retention Engine

This block is the device-side refresh logic of a low-power SDRAM model. It holds an internal refresh pointer made of a row part and a bank part. The pointer moves forward by one on every refresh event, so a refresh command carries no address at all. There are two sources of events. While the device is in normal operation, an auto-refresh command pulse makes one event. While the device is in self refresh, a private interval timer makes the events and ignores all commands.

The self-refresh interval is set through an extended-mode write. A 2-bit field scales a base interval by a power of two, so a hotter part can use a shorter interval. The same write also loads a bank-enable mask. In self refresh, an event that points at a disabled bank refreshes nothing. Auto refresh ignores the mask. No precharge is needed after a refresh; the row restores itself.

Each refresh that is performed raises a one-cycle strobe together with the bank and row it served. The strobe can feed a memory-array model or a checker. The block also tracks the age of every row. A probe port reports whether a chosen row still holds its data. A row whose age reaches the retention limit is marked lost for good.

Top module: `rfsh_engine`

## Requirements
- R1: After reset, rf_stb is 0, the refresh pointer is at bank 0 row 0, the interval select is 0, the bank mask is all ones, and every row reads valid on the probe port.
- R2: Outside self refresh, an ar_cmd sampled at a clock edge makes rf_stb 1 in the following cycle, with rf_bank/rf_row equal to the pointer before the edge. The pointer then advances row first; after the last row it goes to row 0 of the next bank.
- R3: An event at the last row of the last bank returns the pointer to row 0 of bank 0.
- R4: An auto refresh is always performed, even when the bank mask is all zeros.
- R5: While sr_mode is 1, ar_cmd has no effect. The timer makes an event on the P-th consecutive edge with sr_mode high and every P edges after that. The timer restarts from zero each time self refresh is entered.
- R6: The timer interval is P = SR_BASE * 2^sel, where sel is the 2-bit interval field that was last written.
- R7: In self refresh, an event whose pointer bank has mask bit 0 gives no strobe and refreshes no row, but the pointer still advances.
- R8: emr_wr loads emr_period_sel and emr_bank_en at that edge only when sr_mode is 0. A write while sr_mode is 1 is ignored.
- R9: A row not refreshed for TREF consecutive edges reads invalid on probe_valid from then on, even if it is refreshed later.
- R10: A refresh performed on a row that is still valid sets its age to zero, so it stays valid for another TREF edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ar_cmd | input | 1 | Auto-refresh command pulse |
| sr_mode | input | 1 | 1 while the device is in self refresh |
| emr_wr | input | 1 | Extended-mode register write strobe |
| emr_period_sel | input | 2 | Self-refresh interval select |
| emr_bank_en | input | BANKS | Self-refresh bank-enable mask, bit b for bank b |
| probe_bank | input | log2(BANKS) | Bank of the row to probe |
| probe_row | input | log2(ROWS) | Row to probe |
| rf_stb | output | 1 | One-cycle strobe for a refresh that was performed |
| rf_bank | output | log2(BANKS) | Bank of the last refresh performed |
| rf_row | output | log2(ROWS) | Row of the last refresh performed |
| probe_valid | output | 1 | 1 while the probed row still holds its data |

## Verification
The tests start with back-to-back auto refreshes over the full address space. This separates the row-first stepping order and the wrap to bank 0 from other possible orders. Auto refresh with an all-zero mask checks that the mask applies only to self refresh. A timed self-refresh entry at one interval select measures the interval itself. A long self-refresh run with a single enabled bank separates performed refreshes from skipped ones, and it makes unrefreshed rows age past the retention limit. In the middle of that run a mask write is attempted, which shows whether writes are ignored in self refresh. A seeded random mix of commands, mode changes, mode writes and probes is then checked cycle by cycle against a reference model in the bench.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Self-refresh interval in clock edges for a given select code.
  function automatic int unsigned sr_period(input int unsigned base,
                                            input int unsigned sel);
    return base << sel;
  endfunction

  // Flat position of a (bank,row) pair within the retention array.
  function automatic int unsigned flat_index(input int unsigned bank,
                                             input int unsigned row,
                                             input int unsigned rows);
    return bank * rows + row;
  endfunction

endpackage

// File: rtl/rfsh_sr_timer.sv
module rfsh_sr_timer #(
  parameter int unsigned SR_BASE = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned MAX_P = SR_BASE << ((1 << SEL_W) - 1);
  localparam int unsigned TW    = $clog2(MAX_P + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] lim;

  assign lim  = TW'(rfsh_pkg::sr_period(SR_BASE, 32'(sel)) - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_addr_ctr.sv
module rfsh_addr_ctr #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned BANKS = 4,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank
);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(BANKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row  <= '0;
      bank <= '0;
    end else if (adv) begin
      if (row == ROW_LAST) begin
        row  <= '0;
        bank <= (bank == BANK_LAST) ? '0 : bank + 1'b1;
      end else begin
        row <= row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfsh_retention.sv
module rfsh_retention #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned BANKS = 4,
  parameter int unsigned TREF  = 256,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned N      = ROWS * BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [BANK_W-1:0] hit_bank,
  input  logic [ROW_W-1:0]  hit_row,
  input  logic [BANK_W-1:0] probe_bank,
  input  logic [ROW_W-1:0]  probe_row,
  output logic              probe_valid,
  output logic [N-1:0]      valid_vec
);
  localparam int unsigned AGE_W = $clog2(TREF + 1);
  localparam int unsigned IDX_W = $clog2(N);
  localparam logic [AGE_W-1:0] LIMIT = AGE_W'(TREF);

  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] probe_idx;

  assign hit_idx   = IDX_W'(rfsh_pkg::flat_index(32'(hit_bank), 32'(hit_row), ROWS));
  assign probe_idx = IDX_W'(rfsh_pkg::flat_index(32'(probe_bank), 32'(probe_row), ROWS));

  for (genvar i = 0; i < N; i++) begin : g_age
    logic [AGE_W-1:0] age;
    logic             here;
    assign here = hit && (hit_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    age <= '0;
      else if (here && age < LIMIT)  age <= '0;
      else if (age < LIMIT)          age <= age + 1'b1;
    end
    assign valid_vec[i] = (age < LIMIT);
  end

  assign probe_valid = valid_vec[probe_idx];
endmodule

// File: rtl/rfsh_engine.sv
module rfsh_engine #(
  parameter int unsigned ROWS    = 8,
  parameter int unsigned BANKS   = 4,
  parameter int unsigned TREF    = 256,
  parameter int unsigned SR_BASE = 4,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_cmd,
  input  logic              sr_mode,
  input  logic              emr_wr,
  input  logic [SEL_W-1:0]  emr_period_sel,
  input  logic [BANKS-1:0]  emr_bank_en,
  input  logic [BANK_W-1:0] probe_bank,
  input  logic [ROW_W-1:0]  probe_row,
  output logic              rf_stb,
  output logic [BANK_W-1:0] rf_bank,
  output logic [ROW_W-1:0]  rf_row,
  output logic              probe_valid
);
  localparam int unsigned N = ROWS * BANKS;

  logic [SEL_W-1:0]  sel_q;
  logic [BANKS-1:0]  mask_q;
  logic              sr_tick;
  logic              evt;
  logic              do_rf;
  logic [ROW_W-1:0]  cnt_row;
  logic [BANK_W-1:0] cnt_bank;
  logic [N-1:0]      valid_vec;

  // Mode register: frozen while the device refreshes itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mask_q <= '1;
    end else if (emr_wr && !sr_mode) begin
      sel_q  <= emr_period_sel;
      mask_q <= emr_bank_en;
    end
  end

  rfsh_sr_timer #(.SR_BASE(SR_BASE), .SEL_W(SEL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(sr_mode), .sel(sel_q), .tick(sr_tick)
  );

  assign evt   = (ar_cmd && !sr_mode) || sr_tick;
  assign do_rf = evt && (!sr_mode || mask_q[cnt_bank]);

  rfsh_addr_ctr #(.ROWS(ROWS), .BANKS(BANKS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(evt), .row(cnt_row), .bank(cnt_bank)
  );

  rfsh_retention #(.ROWS(ROWS), .BANKS(BANKS), .TREF(TREF)) u_ret (
    .clk(clk), .rst_n(rst_n), .hit(do_rf), .hit_bank(cnt_bank),
    .hit_row(cnt_row), .probe_bank(probe_bank), .probe_row(probe_row),
    .probe_valid(probe_valid), .valid_vec(valid_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_stb  <= 1'b0;
      rf_bank <= '0;
      rf_row  <= '0;
    end else begin
      rf_stb <= do_rf;
      if (do_rf) begin
        rf_bank <= cnt_bank;
        rf_row  <= cnt_row;
      end
    end
  end
endmodule

// File: rtl/rfsh_engine_chk.sv
module rfsh_engine_chk #(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ar_cmd,
  input logic              sr_mode,
  input logic              rf_stb,
  input logic [BANK_W-1:0] rf_bank,
  input logic              evt,
  input logic              sr_tick,
  input logic [ROW_W-1:0]  cnt_row,
  input logic [BANK_W-1:0] cnt_bank,
  input logic [1:0]        sel_q,
  input logic [BANKS-1:0]  mask_q,
  input logic [ROWS*BANKS-1:0] valid_vec
);
  localparam int unsigned TOTAL = ROWS * BANKS;
  logic [31:0] lin;
  assign lin = 32'(cnt_bank) * ROWS + 32'(cnt_row);

  p_ar_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_cmd && !sr_mode |=> rf_stb);
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt && lin != TOTAL - 1 |=> lin == $past(lin) + 1);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cnt_row) && $stable(cnt_bank));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt && lin == TOTAL - 1 |=> lin == 0);
  p_ar_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ar_cmd && !sr_mode && mask_q == '0 |=> rf_stb);
  p_sr_no_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_mode && !sr_tick |=> !rf_stb);
  p_sr_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_stb && $past(sr_mode) |-> (($past(mask_q) >> rf_bank) & 1) != 0);
  p_emr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_mode |=> $stable(sel_q) && $stable(mask_q));
  p_loss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec & ~$past(valid_vec)) == '0);
endmodule

bind rfsh_engine rfsh_engine_chk #(
  .ROWS(ROWS), .BANKS(BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ar_cmd(ar_cmd), .sr_mode(sr_mode),
  .rf_stb(rf_stb), .rf_bank(rf_bank), .evt(evt), .sr_tick(sr_tick),
  .cnt_row(cnt_row), .cnt_bank(cnt_bank), .sel_q(sel_q), .mask_q(mask_q),
  .valid_vec(valid_vec)
);

// File: tb/tb_rfsh_engine.sv
module tb_rfsh_engine;
  localparam int CLK_P   = 10;
  localparam int ROWS    = 8;
  localparam int BANKS   = 4;
  localparam int TREF    = 256;
  localparam int SR_BASE = 4;
  localparam int N       = ROWS * BANKS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ar_cmd = 0, sr_mode = 0, emr_wr = 0;
  logic [1:0] emr_period_sel = '0;
  logic [3:0] emr_bank_en = '0;
  logic [1:0] probe_bank = '0;
  logic [2:0] probe_row = '0;
  logic rf_stb, probe_valid;
  logic [1:0] rf_bank;
  logic [2:0] rf_row;

  rfsh_engine #(.ROWS(ROWS), .BANKS(BANKS), .TREF(TREF), .SR_BASE(SR_BASE)) dut (
    .clk(clk), .rst_n(rst_n), .ar_cmd(ar_cmd), .sr_mode(sr_mode),
    .emr_wr(emr_wr), .emr_period_sel(emr_period_sel), .emr_bank_en(emr_bank_en),
    .probe_bank(probe_bank), .probe_row(probe_row), .rf_stb(rf_stb),
    .rf_bank(rf_bank), .rf_row(rf_row), .probe_valid(probe_valid)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  int m_row, m_bank, m_tmr, m_sel;
  logic [3:0] m_mask;
  int m_age [N];

  function automatic int exp_period(int sel);
    int p = SR_BASE;
    for (int k = 0; k < sel; k++) p = p * 2;
    return p;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_row = 0; m_bank = 0; m_tmr = 0; m_sel = 0; m_mask = 4'hF;
    for (int i = 0; i < N; i++) m_age[i] = 0;
  endtask

  // One clock cycle: drive, advance the model, check after the edge.
  task automatic step(bit ar, bit srm, bit wr, int wsel, logic [3:0] wmask,
                      int pb, int pr, output bit got);
    int p, eb, er, idx;
    bit tick, evt, dorf;
    @(negedge clk);
    ar_cmd = ar; sr_mode = srm; emr_wr = wr;
    emr_period_sel = 2'(wsel); emr_bank_en = wmask;
    probe_bank = 2'(pb); probe_row = 3'(pr);
    p    = exp_period(m_sel);
    tick = srm && (m_tmr == p - 1);
    evt  = (ar && !srm) || tick;
    dorf = evt && (!srm || m_mask[m_bank]);
    eb = m_bank; er = m_row;
    idx = m_bank * ROWS + m_row;
    for (int i = 0; i < N; i++) begin
      if (dorf && i == idx && m_age[i] < TREF) m_age[i] = 0;
      else if (m_age[i] < TREF) m_age[i]++;
    end
    if (evt) begin
      m_row++;
      if (m_row == ROWS) begin m_row = 0; m_bank = (m_bank + 1) % BANKS; end
    end
    m_tmr = (!srm || tick) ? 0 : m_tmr + 1;
    if (wr && !srm) begin m_sel = wsel; m_mask = wmask; end
    @(posedge clk); #1;
    chk(rf_stb === dorf, srm ? "R5" : "R2", "rf_stb", int'(rf_stb), int'(dorf));
    if (dorf) begin
      chk(rf_bank === 2'(eb), "R2", "rf_bank", int'(rf_bank), eb);
      chk(rf_row === 3'(er), "R2", "rf_row", int'(rf_row), er);
    end
    chk(probe_valid === (m_age[pb * ROWS + pr] < TREF), "R9/R10", "probe_valid",
        int'(probe_valid), int'(m_age[pb * ROWS + pr] < TREF));
    got = rf_stb;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit g;
    int n, other;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state seen at the ports
    #1;
    chk(rf_stb === 1'b0, "R1", "rf_stb after reset", int'(rf_stb), 0);
    for (int i = 0; i < N; i++) begin
      probe_bank = 2'(i / ROWS); probe_row = 3'(i % ROWS); #1;
      chk(probe_valid === 1'b1, "R1", "probe after reset", int'(probe_valid), 1);
    end
    // R2: a few auto refreshes with idle gaps
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 0, 0, 0, 0, k, g);
      step(0, 0, 0, 0, 0, 0, 0, g);
    end
    // R3: complete the sweep, next one wraps
    for (int k = 3; k < N; k++) step(1, 0, 0, 0, 0, k / ROWS, k % ROWS, g);
    step(1, 0, 0, 0, 0, 0, 0, g);
    chk(rf_bank === 2'd0 && rf_row === 3'd0, "R3", "wrap address",
        int'({rf_bank, rf_row}), 0);
    // R4: auto refresh with an all-zero mask
    step(0, 0, 1, 0, 4'h0, 0, 0, g);
    step(1, 0, 0, 0, 0, 0, 0, g);
    chk(g == 1, "R4", "auto refresh under zero mask", int'(g), 1);
    // R6 and R5: interval select 2, commands offered during self refresh
    step(0, 0, 1, 2, 4'hF, 0, 0, g);
    n = 0; g = 0;
    while (!g && n < 100) begin
      step(1, 1, 0, 0, 0, 0, 0, g);
      n++;
    end
    chk(n == exp_period(2), "R6", "edges to first self refresh", n, exp_period(2));
    chk(n == 16, "R5", "ar_cmd ignored until timer event", n, 16);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, g);
    // R7 and R8: only bank 0 enabled, long self refresh
    step(0, 0, 1, 0, 4'b0001, 0, 0, g);
    other = 0;
    for (int k = 0; k < 200; k++) begin
      step($urandom_range(0, 1), 1, 0, 0, 0, $urandom_range(0, 3), $urandom_range(0, 7), g);
      if (g && rf_bank != 0) other++;
    end
    chk(other == 0, "R7", "strobes for disabled banks", other, 0);
    step(0, 1, 1, 3, 4'hF, 0, 0, g);
    other = 0;
    for (int k = 0; k < 200; k++) begin
      step(0, 1, 0, 0, 0, $urandom_range(0, 3), $urandom_range(0, 7), g);
      if (g && rf_bank != 0) other++;
    end
    chk(other == 0, "R8", "mask write in self refresh ignored", other, 0);
    step(0, 1, 0, 0, 0, 1, 0, g);
    chk(probe_valid === 1'b0, "R9", "disabled bank row lost", int'(probe_valid), 0);
    step(0, 1, 0, 0, 0, 0, 5, g);
    chk(probe_valid === 1'b1, "R10", "enabled bank row kept", int'(probe_valid), 1);
    step(0, 0, 0, 0, 0, 0, 0, g);
    // random mix
    begin
      bit srm = 0;
      for (int k = 0; k < 3000; k++) begin
        if ($urandom_range(0, 199) == 0) srm = !srm;
        step($urandom_range(0, 2) == 0, srm, $urandom_range(0, 49) == 0,
             $urandom_range(0, 3), 4'($urandom_range(0, 15)),
             $urandom_range(0, 3), $urandom_range(0, 7), g);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule